// File: doc/BRIEF.md
# Cascadable Three-Input Logic Cell Pair

This block holds a row of small programmable logic cells, two by default. Each cell takes three single-bit inputs, labelled A, B and C, and drives one output. A configuration byte chooses what each cell computes. The cell can be off, or it can form the AND, OR or XOR of all three inputs. It can also act as an edge-triggered flip-flop, or copy any one input straight through. Each input can be inverted on its own before it enters the cell, and so can the cell's result.

Every cell after the first can take the output of the cell before it in place of its own A pin. This lets two cells form a deeper function, for example a gated flip-flop or a five-input term.

The configuration bytes are loaded through a synchronous write port with one address per cell. Both bytes can be read back through a combinational read port. The cells are purely combinational, apart from the flip-flop. That flip-flop is clocked and cleared by the cell's own conditioned inputs, not by the system clock.

Top module: `cellpair_top`

## Requirements
- R1: After a synchronous reset, every configuration byte reads back 0x00, and every cell output is 0.
- R2: A write with `wr_en` high at a rising `clk` edge loads `wr_data` into the byte at `wr_addr`, where address 0 is the first cell and address 1 is the second. The new byte reads back on `rd_data` from that edge on. Writes to one cell leave the other cell's byte unchanged.
- R3: The function field is bits 2:0 of a cell's byte. Code 000 gives 0, 001 gives the AND of the three conditioned inputs, 010 gives their OR and 011 gives their XOR.
- R4: Function codes 101, 110 and 111 pass the conditioned A, B or C input, respectively.
- R5: Bits 3, 4 and 5 of a cell's byte invert input A, B and C, respectively, before the input is used by any function, including the flip-flop.
- R6: Bit 6 of a cell's byte inverts the cell's result. In the off mode this makes the output 1.
- R7: With function code 100, the cell output is a flip-flop. It captures conditioned A on each rising edge of conditioned B and holds its value otherwise.
- R8: A high conditioned C clears the flip-flop at once, without waiting for `clk`, and holds it at 0 while C stays high, whatever happens on B.
- R9: Bit 7 of the second cell's byte selects cascade. When it is set, the second cell's A input is the first cell's output, taken after the first cell's output inversion. That signal is then subject to the second cell's own A inversion, and the second cell's A pin is ignored.
- R10: Bit 7 of the first cell's byte is not stored. It reads back as 0 and has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration registers |
| rst | input | 1 | Synchronous active-high reset of the configuration bytes |
| wr_en | input | 1 | Write strobe for the configuration port |
| wr_addr | input | 1 | Cell index to write |
| wr_data | input | 8 | Configuration byte to write |
| rd_addr | input | 1 | Cell index to read |
| rd_data | output | 8 | Configuration byte of the cell at `rd_addr` |
| pin_a | input | 2 | Input A of each cell, bit i for cell i |
| pin_b | input | 2 | Input B of each cell |
| pin_c | input | 2 | Input C of each cell |
| y_out | output | 2 | Output of each cell |

## Verification
The hardest behaviour to reach from the ports is the flip-flop. Its clock and clear come from conditioned inputs, so a configuration write that flips an invert bit is itself a clock edge or a clear. A cascaded second cell whose A input follows a toggling first cell adds more such edges. The stimulus therefore changes only one conditioned signal at a time. Each configuration change is split into two writes, so that the B invert bit moves on its own. Pins are changed cell by cell, and the first cell is changed before the second.

Every flip-flop is first cleared by writing a C inversion while its C pin is low. After that, exhaustive sweeps of each byte against all pin patterns visit every edge and clear situation, with the behavioural model tracking the stored bit.

// File: rtl/cellpair_pkg.sv
package cellpair_pkg;

    localparam int CFG_W = 8;

    // Function field codes, bits 2:0 of a cell byte
    typedef enum logic [2:0] {
        FN_OFF    = 3'd0,
        FN_AND    = 3'd1,
        FN_OR     = 3'd2,
        FN_XOR    = 3'd3,
        FN_DFF    = 3'd4,
        FN_PASS_A = 3'd5,
        FN_PASS_B = 3'd6,
        FN_PASS_C = 3'd7
    } cell_fn_e;

    // One configuration byte, MSB first
    typedef struct packed {
        logic     link;   // bit 7: take previous cell output as A
        logic     inv_y;  // bit 6
        logic     inv_c;  // bit 5
        logic     inv_b;  // bit 4
        logic     inv_a;  // bit 3
        cell_fn_e fn;     // bits 2:0
    } cell_cfg_t;

    // Conditioned inputs of a cell plus its stored bit
    typedef struct packed {
        logic a;
        logic b;
        logic c;
        logic q;
    } cell_sig_t;

    // Bits kept in storage: the first cell has nothing to cascade from
    function automatic logic [CFG_W-1:0] keep_mask(int idx);
        return (idx == 0) ? 8'h7F : 8'hFF;
    endfunction

    function automatic logic cell_function(cell_fn_e fn, cell_sig_t s);
        logic r;
        r = 1'b0;
        case (fn)
            FN_OFF:    r = 1'b0;
            FN_AND:    r = s.a & s.b & s.c;
            FN_OR:     r = s.a | s.b | s.c;
            FN_XOR:    r = s.a ^ s.b ^ s.c;
            FN_DFF:    r = s.q;
            FN_PASS_A: r = s.a;
            FN_PASS_B: r = s.b;
            FN_PASS_C: r = s.c;
            default:   r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cellpair_regs.sv
module cellpair_regs
    import cellpair_pkg::*;
#(
    parameter int NCELL  = 2,
    parameter int ADDR_W = 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [CFG_W-1:0]        wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [CFG_W-1:0]        rd_data,
    output cell_cfg_t [NCELL-1:0]   cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NCELL; i++) begin
                if (wr_addr == ADDR_W'(i)) begin
                    cfg[i] <= cell_cfg_t'(wr_data & keep_mask(i));
                end
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NCELL; i++) begin
            if (rd_addr == ADDR_W'(i)) begin
                rd_data = cfg[i];
            end
        end
    end

endmodule

// File: rtl/logic_cell.sv
module logic_cell
    import cellpair_pkg::*;
(
    input  cell_cfg_t cfg,
    input  logic      pin_a,
    input  logic      pin_b,
    input  logic      pin_c,
    input  logic      chain_in,
    output logic      y
);

    logic      src_a;
    logic      cond_a;
    logic      cond_b;
    logic      cond_c;
    logic      state_q;
    cell_sig_t sig;

    assign src_a  = cfg.link ? chain_in : pin_a;
    assign cond_a = src_a ^ cfg.inv_a;
    assign cond_b = pin_b ^ cfg.inv_b;
    assign cond_c = pin_c ^ cfg.inv_c;

    // Storage element: clocked by conditioned B, cleared by conditioned C
    always_ff @(posedge cond_b or posedge cond_c) begin
        if (cond_c) begin
            state_q <= 1'b0;
        end else begin
            state_q <= cond_a;
        end
    end

    assign sig = '{a: cond_a, b: cond_b, c: cond_c, q: state_q};
    assign y   = cell_function(cfg.fn, sig) ^ cfg.inv_y;

endmodule

// File: rtl/cellpair_top.sv
module cellpair_top
    import cellpair_pkg::*;
#(
    parameter  int NCELL  = 2,
    localparam int ADDR_W = (NCELL > 1) ? $clog2(NCELL) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [CFG_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [CFG_W-1:0]   rd_data,
    input  logic [NCELL-1:0]   pin_a,
    input  logic [NCELL-1:0]   pin_b,
    input  logic [NCELL-1:0]   pin_c,
    output logic [NCELL-1:0]   y_out
);

    cell_cfg_t [NCELL-1:0] cfg;
    logic      [NCELL-1:0] chain;

    cellpair_regs #(
        .NCELL  (NCELL),
        .ADDR_W (ADDR_W)
    ) i_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .cfg     (cfg)
    );

    for (genvar gi = 0; gi < NCELL; gi++) begin : g_cell
        if (gi == 0) begin : g_head
            assign chain[gi] = 1'b0;
        end else begin : g_link
            assign chain[gi] = y_out[gi-1];
        end

        logic_cell i_cell (
            .cfg      (cfg[gi]),
            .pin_a    (pin_a[gi]),
            .pin_b    (pin_b[gi]),
            .pin_c    (pin_c[gi]),
            .chain_in (chain[gi]),
            .y        (y_out[gi])
        );
    end

endmodule

// File: rtl/cellpair_chk.sv
module cellpair_chk #(
    parameter int NCELL  = 2,
    parameter int ADDR_W = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_data,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [7:0]        rd_data,
    input logic [NCELL-1:0]  pin_a,
    input logic [NCELL-1:0]  pin_b,
    input logic [NCELL-1:0]  pin_c,
    input logic [NCELL-1:0]  y_out
);

    // R1
    reset_clean_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (rd_data == 8'h00 && y_out == '0));

    // R10
    head_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == '0) |-> (rd_data[7] == 1'b0));

    // R3
    and_fn_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == '0 && rd_data[6:0] == 7'b0000001)
            |-> (y_out[0] == (pin_a[0] & pin_b[0] & pin_c[0])));

    // R4
    pass_b_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == '0 && rd_data[6:0] == 7'b0000110) |-> (y_out[0] == pin_b[0]));

    // R6
    off_inv_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == '0 && rd_data[6:0] == 7'b1000000) |-> (y_out[0] == 1'b1));

    if (NCELL > 1) begin : g_pair
        // R2
        readback_chk: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(wr_en) && $past(wr_addr) == ADDR_W'(1) && rd_addr == ADDR_W'(1))
                |-> (rd_data == $past(wr_data)));

        // R9
        cascade_chk: assert property (@(posedge clk) disable iff (rst)
            (rd_addr == ADDR_W'(1) && rd_data == 8'h85) |-> (y_out[1] == y_out[0]));
    end

endmodule

bind cellpair_top cellpair_chk #(.NCELL(NCELL), .ADDR_W(ADDR_W)) i_cellpair_chk (.*);

// File: tb/test_cellpair_top.sv
`timescale 1ns/1ps
module test_cellpair_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [0:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [0:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [1:0] pin_a = '0;
    logic [1:0] pin_b = '0;
    logic [1:0] pin_c = '0;
    logic [1:0] y_out;

    int    n_cmp  = 0;
    int    n_bad  = 0;
    bit    done   = 1'b0;
    string cur_req = "R1";

    // behavioural reference state
    logic [7:0] mcfg [2];
    bit         mq [2];
    bit         mprevb [2];
    bit         my [2];

    cellpair_top #(.NCELL(2)) i_cellpair_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pin_a(pin_a), .pin_b(pin_b),
        .pin_c(pin_c), .y_out(y_out)
    );

    always #5 clk = ~clk;

    task automatic settle();
        for (int i = 0; i < 2; i++) begin
            bit ra, ca, cb, cc, f;
            ra = (i == 1 && mcfg[1][7]) ? my[0] : pin_a[i];
            ca = ra ^ mcfg[i][3];
            cb = pin_b[i] ^ mcfg[i][4];
            cc = pin_c[i] ^ mcfg[i][5];
            if (cc) mq[i] = 1'b0;
            else if (cb && !mprevb[i]) mq[i] = ca;
            mprevb[i] = cb;
            case (mcfg[i][2:0])
                3'd0: f = 1'b0;
                3'd1: f = ca & cb & cc;
                3'd2: f = ca | cb | cc;
                3'd3: f = ca ^ cb ^ cc;
                3'd4: f = mq[i];
                3'd5: f = ca;
                3'd6: f = cb;
                default: f = cc;
            endcase
            my[i] = f ^ mcfg[i][6];
        end
    endtask

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            check({7'd0, y_out[0]}, {7'd0, my[0]}, cur_req, "y0");
            check({7'd0, y_out[1]}, {7'd0, my[1]}, cur_req, "y1");
            check(rd_data, mcfg[rd_addr], cur_req, "rd_data");
        end
    end

    task automatic raw_write(input bit addr, input logic [7:0] v);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = addr; wr_data = v;
        @(posedge clk); #1;
        wr_en = 1'b0;
        mcfg[addr] = v & (addr ? 8'hFF : 8'h7F);
        settle();
    endtask

    // B inversion moves in a write of its own
    task automatic cfg_write(input bit addr, input logic [7:0] v);
        raw_write(addr, {v[7:5], mcfg[addr][4], v[3:0]});
        raw_write(addr, v);
    endtask

    task automatic set_pins(input logic [1:0] a, input logic [1:0] b, input logic [1:0] c);
        @(posedge clk); #1;
        for (int i = 0; i < 2; i++) begin
            pin_a[i] = a[i]; #0.4; settle();
            pin_b[i] = b[i]; #0.4; settle();
            pin_c[i] = c[i]; #0.4; settle();
        end
    endtask

    function automatic string tag_for(input logic [7:0] v, input bit second);
        if (second && v[7]) return "R9";
        if (v[6]) return "R6";
        if (v[5:3] != 3'd0) return "R5";
        case (v[2:0])
            3'd4:       return "R7";
            3'd5, 3'd6, 3'd7: return "R4";
            default:    return "R3";
        endcase
    endfunction

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 2; i++) begin
            mcfg[i] = '0; mq[i] = 0; mprevb[i] = 0; my[i] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state of both bytes and both outputs
        @(negedge clk);
        check(rd_data, 8'h00, "R1", "byte0 after reset");
        check({6'd0, y_out}, 8'h00, "R1", "outputs after reset");
        rd_addr = 1'b1; #1;
        check(rd_data, 8'h00, "R1", "byte1 after reset");
        rd_addr = 1'b0;

        // R8: clear both stored bits through a C inversion
        cur_req = "R8";
        cfg_write(0, 8'h20); cfg_write(1, 8'h20);
        cfg_write(0, 8'h00); cfg_write(1, 8'h00);

        // first cell: every byte against every pin pattern
        rd_addr = 1'b0;
        for (int v = 0; v < 128; v++) begin
            cur_req = tag_for(8'(v), 1'b0);
            cfg_write(0, 8'(v));
            for (int p = 0; p < 8; p++)
                set_pins({1'($urandom % 2), 1'(p)}, {1'($urandom % 2), 1'(p >> 1)},
                         {1'($urandom % 2), 1'(p >> 2)});
        end

        // second cell, with and without cascade
        rd_addr = 1'b1;
        cfg_write(0, 8'h03);
        for (int v = 0; v < 256; v++) begin
            cur_req = tag_for(8'(v), 1'b1);
            cfg_write(1, 8'(v));
            for (int p = 0; p < 8; p++)
                set_pins({1'(p), 1'($urandom % 2)}, {1'(p >> 1), 1'($urandom % 2)},
                         {1'(p >> 2), 1'($urandom % 2)});
        end

        // R7 / R8 directed sequence on the first cell
        rd_addr = 1'b0;
        cfg_write(1, 8'h00);
        cur_req = "R7";
        cfg_write(0, 8'h04);
        set_pins(2'b00, 2'b00, 2'b00);
        set_pins(2'b01, 2'b00, 2'b00);
        set_pins(2'b01, 2'b01, 2'b00);
        @(negedge clk); check({7'd0, y_out[0]}, 8'h01, "R7", "capture 1 on B rise");
        set_pins(2'b00, 2'b01, 2'b00);
        @(negedge clk); check({7'd0, y_out[0]}, 8'h01, "R7", "hold without edge");
        set_pins(2'b00, 2'b00, 2'b00);
        set_pins(2'b00, 2'b01, 2'b00);
        @(negedge clk); check({7'd0, y_out[0]}, 8'h00, "R7", "capture 0 on B rise");
        set_pins(2'b01, 2'b00, 2'b00);
        set_pins(2'b01, 2'b01, 2'b00);
        cur_req = "R8";
        set_pins(2'b01, 2'b01, 2'b01);
        @(negedge clk); check({7'd0, y_out[0]}, 8'h00, "R8", "clear by C");
        set_pins(2'b01, 2'b00, 2'b01);
        set_pins(2'b01, 2'b01, 2'b01);
        @(negedge clk); check({7'd0, y_out[0]}, 8'h00, "R8", "held clear during B rise");

        // R10: reserved bit of the first cell
        cur_req = "R10";
        cfg_write(0, 8'h81);
        set_pins(2'b01, 2'b01, 2'b01);
        @(negedge clk);
        check(rd_data, 8'h01, "R10", "reserved bit reads 0");
        check({7'd0, y_out[0]}, 8'h01, "R10", "AND unaffected by bit 7");

        // R2: readback of the second cell, first cell untouched
        cur_req = "R2";
        cfg_write(1, 8'hA5);
        rd_addr = 1'b1;
        @(negedge clk); check(rd_data, 8'hA5, "R2", "byte1 readback");
        rd_addr = 1'b0; #1;
        check(rd_data, 8'h01, "R2", "byte0 unchanged");

        // R9: cascade directed: cell0 passes A inverted, cell1 passes its A
        cur_req = "R9";
        cfg_write(0, 8'h45);
        cfg_write(1, 8'h85);
        set_pins(2'b01, 2'b00, 2'b00);
        @(negedge clk); check({6'd0, y_out}, 8'h00, "R9", "cascade of inverted 1");
        set_pins(2'b10, 2'b00, 2'b00);
        @(negedge clk); check({6'd0, y_out}, 8'h03, "R9", "cascade ignores own A pin");
        cfg_write(1, 8'h8D);
        @(negedge clk); check({6'd0, y_out}, 8'h01, "R9", "cascade then A inversion");

        // mixed random traffic
        cur_req = "R2";
        for (int k = 0; k < 300; k++) begin
            cfg_write(1'($urandom % 2), 8'($urandom));
            rd_addr = 1'($urandom % 2);
            set_pins(2'($urandom), 2'($urandom), 2'($urandom));
        end

        finish_run();
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

endmodule